// File: doc/BRIEF.md
# Space-Vector Phase-Select Sequencer

This block drives the three output modules of a three-input, three-output matrix converter under indirect space-vector modulation. In each switching period it emits a 6-bit word that tells every output module which input phase to connect to. A downstream commutation controller per module acts on each 2-bit field. The word steps through four active vector pairs and then a zero pair. Their lengths come from four duty counts that are loaded once per period. The input-current sector and the output-voltage sector pick which pairs are used.

The words come from a table of 180 entries that is computed when the design is built. Six input sectors, six output sectors and five steps give the 180 entries. A period counter sets the boundaries. At each period boundary the block latches a new sector pair and new duty counts, and it turns the duty counts into running thresholds that saturate at the period end. A strobe marks every cycle in which the emitted word changes. This lets the commutation logic start a sequence only when there is something to commute.

Top module: `svm_phase_seq`

## Requirements
- R1: While reset is low, and in the cycle after release up to the first rising clock edge, `sel_o` is 000000 and `sel_chg_o` is 0.
- R2: A period lasts exactly PERIOD cycles. The first period starts at the first rising edge after reset is released. Every later period starts PERIOD cycles after the previous one, and count 0 of each period already shows that period's first word.
- R3: Counting cycles from 0 within a period, pair ac is emitted for counts [0, ac). Pair ad follows for [ac, ac+ad), then pair bd for [ac+ad, ac+ad+bd), then pair bc for [ac+ad+bd, sum). The zero pair fills the counts from the sum up to PERIOD-1.
- R4: Each running threshold is capped at PERIOD. When the sum reaches PERIOD, the zero pair never appears. When the sum exceeds PERIOD, the later pairs are cut short or left out.
- R5: A duty count of 0 skips its pair entirely. Several pairs may start in the same cycle.
- R6: The word is laid out as bits [5:4] for output 1, [3:2] for output 2 and [1:0] for output 3. The code 01, 10 or 11 selects input 1, 2 or 3.
  - Current vector j (1..6) puts input ((j/2) mod 3)+1 on the positive rail and input (((j+3)/2) mod 3)+1 on the negative rail.
  - Voltage vector j ties output o (0..2) to the positive rail when (j-1-2o) mod 6 is 0, 1 or 5, and to the negative rail otherwise.
  - For input sector n (0..5): a = ((n+5) mod 6)+1 and b = n+1.
  - For output sector m (0..5): c = m+1 and d = ((m+1) mod 6)+1.
  - The four active steps use the pairs (a,c), (a,d), (b,d) and (b,c), in that order.
- R7: The zero word ties all three outputs to one input of current vector b. It uses the positive-rail input if voltage vector c drives two or more outputs high, and the negative-rail input otherwise. Leaving the last active pair therefore moves only one output.
- R8: The word index is 5·output sector + 30·input sector + step, where step runs from 0 to 4. For input sector 0 and output sector 2, the five words are 100110, 100101, 110101, 110111 and 111111.
- R9: Changes to the sector or duty inputs inside a period have no effect until the next period boundary.
- R10: A sector code of 6 or 7 on either sector input is rejected at the boundary. That sector keeps the value latched for the previous period, which is 0 after reset.
- R11: `sel_chg_o` is 1 exactly in the cycles whose `sel_o` differs from the previous cycle's `sel_o`. Before the first period, the previous value counts as 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_sect_i | input | 3 | Input-current sector, 0..5 |
| out_sect_i | input | 3 | Output-voltage sector, 0..5 |
| dur_ac_i | input | DUTY_W (13) | Length of pair ac in cycles |
| dur_ad_i | input | DUTY_W (13) | Length of pair ad in cycles |
| dur_bd_i | input | DUTY_W (13) | Length of pair bd in cycles |
| dur_bc_i | input | DUTY_W (13) | Length of pair bc in cycles |
| sel_o | output | 6 | Phase selects for the three output modules |
| sel_chg_o | output | 1 | High in cycles where sel_o changed |

## Verification
A period boundary and an interval boundary can fall in the same cycle. This happens when a pair ends exactly at PERIOD, or when a zero ac count makes the new period's first word jump straight to a later pair. Several compare events can also fire together when consecutive duty counts are zero. The bench provokes all of these with exact-sum, oversubscribed and zero-count periods on a 40-cycle configuration. Every cycle's word and strobe are compared against values computed from the vector definitions, with the previous period's word carried across the boundary.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;
  localparam int unsigned N_SECT  = 6;
  localparam int unsigned N_STEP  = 5;
  localparam int unsigned N_THR   = 4;
  localparam int unsigned ENTRIES = N_SECT * N_SECT * N_STEP;

  typedef logic [1:0] phase_t;
  typedef logic [5:0] word_t;

  // input phase on the positive rail for current vector idx (0-based)
  function automatic phase_t rail_pos(input int unsigned idx);
    case (idx)
      0: return 2'd1;
      1: return 2'd2;
      2: return 2'd2;
      3: return 2'd3;
      4: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic phase_t rail_neg(input int unsigned idx);
    case (idx)
      0: return 2'd3;
      1: return 2'd3;
      2: return 2'd1;
      3: return 2'd1;
      4: return 2'd2;
      default: return 2'd2;
    endcase
  endfunction

  // bit 2 = output 1 ... bit 0 = output 3, 1 = positive rail
  function automatic logic [2:0] inv_pattern(input int unsigned idx);
    case (idx)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic word_t pair_word(input int unsigned cur, input int unsigned vol);
    word_t w;
    logic [2:0] pat;
    pat = inv_pattern(vol);
    for (int o = 0; o < 3; o++) begin
      w[5-2*o -: 2] = pat[2-o] ? rail_pos(cur) : rail_neg(cur);
    end
    return w;
  endfunction

  function automatic word_t zero_word(input int unsigned cur, input int unsigned vol);
    logic [2:0] pat;
    phase_t     ph;
    pat = inv_pattern(vol);
    ph  = ($countones(pat) >= 2) ? rail_pos(cur) : rail_neg(cur);
    return {ph, ph, ph};
  endfunction

  function automatic word_t table_word(input int unsigned addr);
    int unsigned s_in, s_out, step, va, vb, vc, vd;
    s_in  = addr / (N_SECT * N_STEP);
    s_out = (addr % (N_SECT * N_STEP)) / N_STEP;
    step  = addr % N_STEP;
    va = (s_in + N_SECT - 1) % N_SECT;
    vb = s_in;
    vc = s_out;
    vd = (s_out + 1) % N_SECT;
    case (step)
      0: return pair_word(va, vc);
      1: return pair_word(va, vd);
      2: return pair_word(vb, vd);
      3: return pair_word(vb, vc);
      default: return zero_word(vb, vc);
    endcase
  endfunction
endpackage

// File: rtl/svm_period_timer.sv
module svm_period_timer #(
  parameter int unsigned PERIOD = 5000,
  parameter int unsigned CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset parks on the last count so the first edge opens a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == LAST);

  // R2
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/svm_interval_gen.sv
module svm_interval_gen #(
  parameter int unsigned PERIOD = 5000,
  parameter int unsigned CNT_W  = $clog2(PERIOD),
  parameter int unsigned DUTY_W = $clog2(PERIOD),
  parameter int unsigned N_THR  = 4,
  parameter int unsigned STEP_W = $clog2(N_THR + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [N_THR-1:0][DUTY_W-1:0] dur_i,
  input  logic [CNT_W-1:0]             cnt_i,
  output logic [STEP_W-1:0]            step_o
);
  localparam int unsigned THR_W = $clog2(PERIOD + 1);
  localparam int unsigned SUM_W = DUTY_W + $clog2(N_THR) + 1;

  logic [THR_W-1:0] thr_d [N_THR];
  logic [THR_W-1:0] thr_q [N_THR];
  logic [SUM_W-1:0] acc   [N_THR];

  // running sums, capped at the period end
  generate
    for (genvar k = 0; k < N_THR; k++) begin : g_thr
      if (k == 0) begin : g_first
        assign acc[k] = SUM_W'(dur_i[k]);
      end else begin : g_next
        assign acc[k] = acc[k-1] + SUM_W'(dur_i[k]);
      end
      assign thr_d[k] = (acc[k] >= SUM_W'(PERIOD)) ? THR_W'(PERIOD) : THR_W'(acc[k]);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     thr_q[k] <= '0;
        else if (load_i) thr_q[k] <= thr_d[k];
      end
    end
  endgenerate

  // step = number of compare events already passed
  always_comb begin
    step_o = '0;
    for (int k = 0; k < N_THR; k++) begin
      step_o = step_o + STEP_W'(THR_W'(cnt_i) >= thr_q[k]);
    end
  end

  // R3
  step_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (step_o >= $past(step_o)));

  // R9
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(thr_q[0]) && $stable(thr_q[N_THR-1])));
endmodule

// File: rtl/svm_pair_rom.sv
module svm_pair_rom
  import svm_seq_pkg::*;
#(
  parameter int unsigned DEPTH  = ENTRIES,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output word_t             word_o
);
  word_t tbl [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[i] = table_word(i);
    end
  endgenerate

  assign word_o = (32'(addr_i) < DEPTH) ? tbl[addr_i] : '0;
endmodule

// File: rtl/svm_phase_seq.sv
module svm_phase_seq
  import svm_seq_pkg::*;
#(
  parameter int unsigned PERIOD = 5000,
  parameter int unsigned DUTY_W = $clog2(PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        in_sect_i,
  input  logic [2:0]        out_sect_i,
  input  logic [DUTY_W-1:0] dur_ac_i,
  input  logic [DUTY_W-1:0] dur_ad_i,
  input  logic [DUTY_W-1:0] dur_bd_i,
  input  logic [DUTY_W-1:0] dur_bc_i,
  output logic [5:0]        sel_o,
  output logic              sel_chg_o
);
  localparam int unsigned CNT_W  = $clog2(PERIOD);
  localparam int unsigned STEP_W = $clog2(N_THR + 1);
  localparam int unsigned ADDR_W = $clog2(ENTRIES);

  logic [CNT_W-1:0]             cnt;
  logic                         wrap;
  logic [STEP_W-1:0]            step;
  logic [N_THR-1:0][DUTY_W-1:0] dur;
  logic [2:0]                   in_q, out_q, in_nx, out_nx;
  logic [ADDR_W-1:0]            base_q, base_d, ptr;
  logic                         run_q;
  word_t                        word, prev_q;

  assign dur = {dur_bc_i, dur_bd_i, dur_ad_i, dur_ac_i};

  svm_period_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  svm_interval_gen #(
    .PERIOD(PERIOD), .CNT_W(CNT_W), .DUTY_W(DUTY_W), .N_THR(N_THR), .STEP_W(STEP_W)
  ) u_intv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .dur_i  (dur),
    .cnt_i  (cnt),
    .step_o (step)
  );

  // out-of-range sector codes keep the previous period's sector
  assign in_nx  = (in_sect_i  < 3'(N_SECT)) ? in_sect_i  : in_q;
  assign out_nx = (out_sect_i < 3'(N_SECT)) ? out_sect_i : out_q;
  assign base_d = ADDR_W'(N_STEP) * ADDR_W'(out_nx)
                + ADDR_W'(N_STEP * N_SECT) * ADDR_W'(in_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      out_q  <= '0;
      base_q <= '0;
      run_q  <= 1'b0;
    end else if (wrap) begin
      in_q   <= in_nx;
      out_q  <= out_nx;
      base_q <= base_d;
      run_q  <= 1'b1;
    end
  end

  assign ptr = base_q + ADDR_W'(step);

  svm_pair_rom #(.DEPTH(ENTRIES), .ADDR_W(ADDR_W)) u_rom (
    .addr_i (ptr),
    .word_o (word)
  );

  assign sel_o = run_q ? word : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sel_o;
  end

  assign sel_chg_o = (sel_o != prev_q);

  // R6
  sel_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((sel_o[5:4] != 2'b00) && (sel_o[3:2] != 2'b00) && (sel_o[1:0] != 2'b00)));

  // R10
  sect_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_q < 3'(N_SECT)) && (out_q < 3'(N_SECT)));

  // R8
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr) < ENTRIES);

  // R9
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(base_q));
endmodule

// File: tb/sim_svm_phase_seq.sv
`timescale 1ns/1ps
module sim_svm_phase_seq;
  localparam int P  = 40;
  localparam int DW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    in_s = '0, out_s = '0;
  logic [DW-1:0] dac = '0, dad = '0, dbd = '0, dbc = '0;
  logic [5:0]    sel;
  logic          chg;

  int n_cmp = 0, n_bad = 0;
  int eff_in = 0, eff_out = 0;
  logic [5:0] prev_exp = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  svm_phase_seq #(.PERIOD(P), .DUTY_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_sect_i(in_s), .out_sect_i(out_s),
    .dur_ac_i(dac), .dur_ad_i(dad), .dur_bd_i(dbd), .dur_bc_i(dbc),
    .sel_o(sel), .sel_chg_o(chg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_pos(input int j);
    return ((j / 2) % 3) + 1;
  endfunction

  function automatic int f_neg(input int j);
    return (((j + 3) / 2) % 3) + 1;
  endfunction

  function automatic bit f_hi(input int j, input int o);
    int r;
    r = (j - 1 - 2 * o + 12) % 6;
    return (r == 0) || (r == 1) || (r == 5);
  endfunction

  function automatic logic [5:0] ref_word(input int n, input int m, input int k);
    int a, b, c, d, cur, vol, np, ph;
    logic [5:0] w;
    a = ((n + 5) % 6) + 1; b = n + 1;
    c = m + 1;             d = ((m + 1) % 6) + 1;
    if (k == 4) begin
      np = 0;
      for (int o = 0; o < 3; o++) np += int'(f_hi(c, o));
      ph = (np >= 2) ? f_pos(b) : f_neg(b);
      return {ph[1:0], ph[1:0], ph[1:0]};
    end
    cur = (k < 2) ? a : b;
    vol = (k == 0 || k == 3) ? c : d;
    for (int o = 0; o < 3; o++) begin
      ph = f_hi(vol, o) ? f_pos(cur) : f_neg(cur);
      w[5-2*o -: 2] = ph[1:0];
    end
    return w;
  endfunction

  function automatic int ref_step(input int c, input int a0, input int a1,
                                  input int a2, input int a3);
    int cum, s;
    int dd [4];
    dd = '{a0, a1, a2, a3};
    cum = 0; s = 0;
    for (int k = 0; k < 4; k++) begin
      cum += dd[k];
      if (c >= ((cum > P) ? P : cum)) s++;
    end
    return s;
  endfunction

  task automatic run_period(input int n, input int m, input int a0, input int a1,
                            input int a2, input int a3, input string tag, input bit lit);
    logic [5:0] exp;
    logic [5:0] lw [5];
    int k;
    string t;
    lw = '{6'b100110, 6'b100101, 6'b110101, 6'b110111, 6'b111111};
    in_s = 3'(n); out_s = 3'(m);
    dac = DW'(a0); dad = DW'(a1); dbd = DW'(a2); dbc = DW'(a3);
    if (n < 6) eff_in = n;
    if (m < 6) eff_out = m;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      k = ref_step(c, a0, a1, a2, a3);
      exp = ref_word(eff_in, eff_out, k);
      t = (k == 4) ? "R7" : (c == 0) ? "R2" : (c > P / 2) ? "R9" : tag;
      chk(t, int'(sel), int'(exp));
      chk("R11", int'(chg), int'(exp != prev_exp));
      prev_exp = exp;
      if (lit && (c % 8 == 0)) chk("R8", int'(sel), int'(lw[c / 8]));
      if (c == P / 2) begin
        // scramble inputs mid-period
        in_s = 3'((n + 2) % 8); out_s = 3'((m + 3) % 8);
        dac = DW'(a3 + 1); dad = DW'(0); dbd = DW'(a0 + 5); dbc = DW'(1);
      end
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(sel), 0);
    chk("R1", int'(chg), 0);
    rst_n = 1'b1;
    #1;
    chk("R1", int'(sel), 0);
    chk("R1", int'(chg), 0);

    // R8 worked example: input sector 0, output sector 2
    run_period(0, 2, 8, 8, 8, 8, "R8", 1'b1);
    // R3 distinct lengths
    run_period(3, 4, 3, 6, 9, 12, "R3", 1'b0);
    // R6 sweep of all sector pairs
    for (int n = 0; n < 6; n++)
      for (int m = 0; m < 6; m++)
        run_period(n, m, 3 + n, 2 + m, 5, 4 + ((n + m) % 3), "R6", 1'b0);
    // R5 zero-length pairs
    run_period(1, 4, 0, 7, 0, 5, "R5", 1'b0);
    run_period(2, 0, 0, 0, 0, 0, "R5", 1'b0);
    run_period(5, 5, 4, 0, 0, 9, "R5", 1'b0);
    // R4 exact fill and oversubscription
    run_period(4, 0, 10, 10, 10, 10, "R4", 1'b0);
    run_period(2, 5, 30, 30, 30, 30, "R4", 1'b0);
    run_period(5, 3, 63, 0, 0, 0, "R4", 1'b0);
    run_period(0, 1, 20, 19, 5, 7, "R4", 1'b0);
    // R10 rejected sector codes
    run_period(1, 3, 6, 6, 6, 6, "R10", 1'b0);
    run_period(7, 6, 6, 6, 6, 6, "R10", 1'b0);
    run_period(6, 2, 5, 4, 3, 2, "R10", 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule